// File: doc/BRIEF.md
# Supervisory Reset and Watchdog Generator

This block turns a synchronous supply-below-threshold flag and a three-level watchdog service input into a stretched processor reset. The supply flag holds reset for as long as it is true. When the flag clears, reset stays asserted for a further fixed number of clock cycles. A new dip during that tail restarts the full interval.

The service input arrives as a two-bit level code: driven low, driven high or floating. A watchdog counts how long the input has stayed at one driven level. If that time reaches the timeout, the watchdog fires a reset pulse of the same stretched width. The watchdog stays at zero while reset is asserted or while the input floats. Any change of level restarts it, including a change to or from floating. The reset is provided in both polarities.

The reset width and the watchdog timeout are parameters in clock cycles. Both raw inputs pass through a two-stage synchronizer before use.

Top module: `supv_reset_gen`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it rises, `rst_o` is 1.
- R2: Once the supply flag has been sampled high, `rst_o` is 1 from the third rising edge onward, and it stays 1 for as long as the flag remains high.
- R3: When the supply flag is first sampled low on rising edge b, `rst_o` stays 1 through edge b+RST_CYCLES and is 0 after edge b+RST_CYCLES+1, unless something else triggers reset.
- R4: If the supply flag goes high again while the stretched tail is running, the full RST_CYCLES tail starts over from the new release, as stated in R3.
- R5: With the service input held at one driven level, reset reasserts exactly WD_CYCLES edges after it released. It then lasts RST_CYCLES edges, so the repeat period is WD_CYCLES+RST_CYCLES.
- R6: While the service input floats, the watchdog never fires, however long that lasts.
- R7: Any change of the service input restarts the watchdog count. This includes a single-cycle pulse, and it applies in either direction and to or from floating. Changes spaced fewer than WD_CYCLES-4 cycles apart therefore never cause a reset.
- R8: The watchdog count is held at zero while reset is asserted, so a full WD_CYCLES follows every release.
- R9: `rst_n_o` is always the exact inverse of `rst_o`.
- R10: The service code is 2'b00 = driven low, 2'b01 = driven high, and 2'b1x = floating. Switching between 2'b10 and 2'b11 is not a transition, and both values behave as floating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| supply_low_i | input | 1 | Supply-below-threshold flag, active high |
| svc_lvl_i | input | 2 | Watchdog service level code |
| rst_o | output | 1 | Processor reset, active high |
| rst_n_o | output | 1 | Processor reset, active low |

## Verification
The hardest case to reach from the ports is the exact boundary between a service change that arrives just in time and one that arrives a cycle too late. That boundary depends on the synchronizer latency and on the moment the previous reset released. The bench runs a cycle model of the requirements alongside the design and compares it on every cycle. Random service codes and rare supply dips place changes at arbitrary offsets around the timeout. Directed phases measure the release edge, the re-dip restart, the free-running watchdog period and single-cycle service pulses.

// File: rtl/supv_pkg.sv
package supv_pkg;
  localparam logic [1:0] SVC_LOW   = 2'b00;
  localparam logic [1:0] SVC_HIGH  = 2'b01;
  localparam logic [1:0] SVC_FLOAT = 2'b10;

  // floating is any code with the upper bit set
  function automatic logic svc_floating(input logic [1:0] lvl);
    return lvl[1];
  endfunction

  // collapse both floating codes onto one value
  function automatic logic [1:0] svc_canon(input logic [1:0] lvl);
    return lvl[1] ? SVC_FLOAT : lvl;
  endfunction

  function automatic logic svc_changed(input logic [1:0] now_lvl, input logic [1:0] old_lvl);
    return svc_canon(now_lvl) != svc_canon(old_lvl);
  endfunction
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] INIT  = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] chain [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= INIT;
      else if (s == 0) chain[s] <= d_i;
      else chain[s] <= chain[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/supv_stretch.sv
module supv_stretch #(
  parameter int unsigned RST_CYCLES = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_i,
  input  logic kick_i,
  output logic active_o,
  output logic load_o
);
  localparam int unsigned CW = $clog2(RST_CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(RST_CYCLES);

  logic [CW-1:0] remain_q;

  assign load_o = hold_i | kick_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remain_q <= FULL;
    else if (load_o) remain_q <= FULL;
    else if (remain_q != '0) remain_q <= remain_q - 1'b1;
  end

  assign active_o = (remain_q != '0);
endmodule

// File: rtl/supv_wdog.sv
module supv_wdog
  import supv_pkg::*;
#(
  parameter int unsigned WD_CYCLES = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] lvl_i,
  input  logic       hold_clr_i,
  output logic       trans_o,
  output logic       float_o,
  output logic       bite_o,
  output logic       idle_o
);
  localparam int unsigned CW = $clog2(WD_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(WD_CYCLES - 1);

  logic [1:0]    prev_q;
  logic [CW-1:0] held_q;
  logic          clr;

  assign trans_o = svc_changed(lvl_i, prev_q);
  assign float_o = svc_floating(lvl_i);
  assign clr     = hold_clr_i | float_o | trans_o;
  assign bite_o  = !clr && (held_q == LAST);
  assign idle_o  = (held_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= SVC_FLOAT;
      held_q <= '0;
    end else begin
      prev_q <= svc_canon(lvl_i);
      if (clr || bite_o) held_q <= '0;
      else held_q <= held_q + 1'b1;
    end
  end
endmodule

// File: rtl/supv_reset_gen.sv
module supv_reset_gen
  import supv_pkg::*;
#(
  parameter int unsigned RST_CYCLES  = 20,
  parameter int unsigned WD_CYCLES   = 50,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       supply_low_i,
  input  logic [1:0] svc_lvl_i,
  output logic       rst_o,
  output logic       rst_n_o
);
  logic       sup_s;
  logic [1:0] lvl_s;
  logic       wd_trans, wd_float, wd_bite, wd_idle;
  logic       rst_act, rst_load;

  supv_sync #(.W(1), .STAGES(SYNC_STAGES), .INIT(1'b0)) u_sync_sup (
    .clk(clk), .rst_n(rst_n), .d_i(supply_low_i), .q_o(sup_s)
  );

  supv_sync #(.W(2), .STAGES(SYNC_STAGES), .INIT(SVC_FLOAT)) u_sync_lvl (
    .clk(clk), .rst_n(rst_n), .d_i(svc_lvl_i), .q_o(lvl_s)
  );

  supv_wdog #(.WD_CYCLES(WD_CYCLES)) u_wdog (
    .clk(clk), .rst_n(rst_n), .lvl_i(lvl_s), .hold_clr_i(rst_act),
    .trans_o(wd_trans), .float_o(wd_float), .bite_o(wd_bite), .idle_o(wd_idle)
  );

  supv_stretch #(.RST_CYCLES(RST_CYCLES)) u_stretch (
    .clk(clk), .rst_n(rst_n), .hold_i(sup_s), .kick_i(wd_bite),
    .active_o(rst_act), .load_o(rst_load)
  );

  assign rst_o   = rst_act;
  assign rst_n_o = ~rst_act;
endmodule

// File: rtl/supv_reset_gen_chk.sv
module supv_reset_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic sup_s,
  input logic wd_trans,
  input logic wd_float,
  input logic wd_bite,
  input logic wd_idle,
  input logic rst_o
);
  // R2: a synchronized supply flag forces reset on the next cycle
  assert_supply_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sup_s |=> rst_o);

  // R3: reset never releases in the cycle after the flag was seen high
  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_o) |-> !$past(sup_s));

  // R5: a watchdog expiry starts a reset pulse
  assert_bite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_bite |=> rst_o);

  // R7: a service change clears the count
  assert_trans_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wd_trans |=> wd_idle);

  // R6: floating holds the count at zero
  assert_float_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wd_float |=> wd_idle);

  // R8: the count stays cleared under reset
  assert_rst_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_o |=> wd_idle);
endmodule

bind supv_reset_gen supv_reset_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sup_s(sup_s), .wd_trans(wd_trans),
  .wd_float(wd_float), .wd_bite(wd_bite), .wd_idle(wd_idle), .rst_o(rst_o)
);

// File: tb/supv_reset_gen_bench.sv
module supv_reset_gen_bench;
  localparam int R  = 20;
  localparam int WD = 50;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sup = 1'b0;
  logic [1:0] svc = 2'b10;
  logic rst_o, rst_n_o;
  int n_chk = 0, n_fail = 0;
  bit chk_en = 1'b0;

  always #2 clk = ~clk;

  supv_reset_gen #(.RST_CYCLES(R), .WD_CYCLES(WD)) u_supv_reset_gen (
    .clk(clk), .rst_n(rst_n), .supply_low_i(sup), .svc_lvl_i(svc),
    .rst_o(rst_o), .rst_n_o(rst_n_o)
  );

  task automatic check(input string req, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
    end
  endtask

  function automatic bit same_lvl(input logic [1:0] a, input logic [1:0] b);
    return (a[1] && b[1]) || (a == b);
  endfunction

  // Reference model restating the requirements with a 2-sample input delay
  logic m_s1, m_s2;
  logic [1:0] m_l1, m_l2, m_prev;
  int m_left, m_held;
  always @(posedge clk or negedge rst_n) begin
    bit busy, moved, clear, fire;
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0;
      m_l1 <= 2'b10; m_l2 <= 2'b10; m_prev <= 2'b10;
      m_left <= R; m_held <= 0;
    end else begin
      busy  = (m_left != 0);
      moved = !same_lvl(m_l2, m_prev);
      clear = busy || m_l2[1] || moved;
      fire  = !clear && (m_held == WD - 1);
      m_left <= (m_s2 || fire) ? R : (busy ? m_left - 1 : 0);
      m_held <= (clear || fire) ? 0 : m_held + 1;
      m_prev <= m_l2; m_l2 <= m_l1; m_l1 <= svc;
      m_s2 <= m_s1; m_s1 <= sup;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      check("R2/R3/R5 model", int'(rst_o), int'(m_left != 0));
      check("R9 polarity", int'(rst_n_o), int'(!rst_o));
    end
  end

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  int cnt;

  initial begin
    void'($urandom(32'd20240611));
    // R1: reset state
    edges(3);
    check("R1 reset", int'(rst_o), 1);
    check("R9 reset", int'(rst_n_o), 0);
    @(negedge clk); rst_n = 1'b1;
    edges(1);
    check("R1 after release", int'(rst_o), 1);
    chk_en = 1'b1;
    edges(R + 5);

    // R2/R3: supply flag hold and exact release edge
    @(negedge clk); sup = 1'b1;
    edges(3);
    check("R2 asserted", int'(rst_o), 1);
    edges(10);
    check("R2 still held", int'(rst_o), 1);
    @(negedge clk); sup = 1'b0;
    edges(R + 1);
    check("R3 tail end", int'(rst_o), 1);
    edges(1);
    check("R3 released", int'(rst_o), 0);

    // R4: re-dip mid tail restarts the full interval
    @(negedge clk); sup = 1'b1;
    edges(4);
    @(negedge clk); sup = 1'b0;
    edges(R / 2);
    @(negedge clk); sup = 1'b1;
    edges(3);
    @(negedge clk); sup = 1'b0;
    edges(R + 1);
    check("R4 restarted tail", int'(rst_o), 1);
    edges(1);
    check("R4 released", int'(rst_o), 0);

    // R5/R8: level held high gives a periodic reset
    @(negedge clk); sup = 1'b1; svc = 2'b01;
    edges(6);
    @(negedge clk); sup = 1'b0;
    cnt = 0;
    while (rst_o && cnt < 4 * R) begin edges(1); cnt++; end
    cnt = 0;
    while (!rst_o && cnt < 4 * WD) begin edges(1); cnt++; end
    check("R5 timeout", cnt, WD);
    cnt = 0;
    while (rst_o && cnt < 4 * R) begin edges(1); cnt++; end
    check("R5 pulse width", cnt, R);
    cnt = 0;
    while (!rst_o && cnt < 4 * WD) begin edges(1); cnt++; end
    check("R8 full timeout after pulse", cnt, WD);
    @(negedge clk); svc = 2'b10;
    edges(R + 5);

    // R7: spaced toggles and single-cycle pulses keep reset away
    @(negedge clk); svc = 2'b00;
    cnt = 0;
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < WD - 10; j++) begin edges(1); cnt += int'(rst_o); end
      @(negedge clk); svc = {1'b0, ~svc[0]};
    end
    check("R7 toggles", cnt, 0);
    cnt = 0;
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < WD - 10; j++) begin edges(1); cnt += int'(rst_o); end
      @(negedge clk); svc = 2'b01;
      @(negedge clk); svc = 2'b00;
    end
    check("R7 one-cycle pulses", cnt, 0);

    // R6/R10: floating codes, alternating 10 and 11
    @(negedge clk); svc = 2'b11;
    cnt = 0;
    for (int k = 0; k < 3 * WD; k++) begin
      edges(1); cnt += int'(rst_o);
      if (k % 7 == 0) svc = {1'b1, ~svc[0]};
    end
    check("R6 R10 floating", cnt, 0);

    // random phase against the model
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      if ($urandom % 100 < 6) svc = 2'($urandom % 4);
      if (sup) sup = ($urandom % 5 != 0);
      else sup = ($urandom % 500 == 0);
    end
    @(negedge clk); sup = 1'b0;
    edges(R + 5);

    chk_en = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule